// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block produces the effective address for a memory operand. It adds up to three terms: a base value, an index value shifted left by a 2-bit scale code, and a displacement. The displacement is sign-extended from 8 or 32 bits. A relative mode replaces the base with the address of the following instruction. The three-way sum wraps modulo 2^XLEN. It is registered and appears one clock after the request.

The caller supplies register contents that have already been read, together with decoded control fields. The `lea_op` input selects where the result goes. A normal operand issues a memory request carrying the address. An address-only operation sends the sum to a separate result port for a destination register write. It raises no memory request and leaves the memory address port untouched.

Top module: `agu_core`

## Requirements
- R1: The result equals base term + index term + displacement term modulo 2^XLEN. A disabled base (`base_en`=0), a disabled index (`index_en`=0) or displacement kind "none" each contribute zero.
- R2: The index term is `index_val` shifted left by `scale_code`. Codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: When `index_num` equals 4 (the stack pointer number), the index term is zero even with `index_en`=1. Every other index number is used normally.
- R4: `disp_kind` 2'b01 sign-extends `disp_raw[7:0]` and 2'b10 sign-extends `disp_raw[31:0]`. Kinds 2'b00 and 2'b11 give zero. With kind 2'b01, bits above bit 7 of `disp_raw` have no effect.
- R5: With `pc_rel`=1, the base term is `next_pc` and the index term is zero. The displacement is `disp_raw[31:0]` sign-extended, whatever `base_en`, `index_en` and `disp_kind` say.
- R6: With base and index both disabled and kind 2'b10, the result is the 32-bit absolute address sign-extended to XLEN bits.
- R7: For a valid request with `lea_op`=1, `lea_result` takes the sum, `lea_wr` pulses, `mem_req` stays low and `mem_addr` keeps its value. With `lea_op`=0, `mem_addr` takes the sum, `mem_req` pulses and `lea_result` keeps its value.
- R8: `out_valid` and the selected strobe rise exactly one cycle after a valid request, and back-to-back requests give back-to-back results. A cycle with `in_valid`=0 leaves both strobes low and both result ports unchanged.
- R9: After a synchronous active-low reset, `out_valid`, `mem_req`, `lea_wr`, `mem_addr` and `lea_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| lea_op | input | 1 | 1: address-only result, 0: memory access |
| base_en | input | 1 | Base term present |
| base_val | input | XLEN | Base register contents |
| index_en | input | 1 | Index term present |
| index_num | input | RNUM_W | Register number of the index |
| index_val | input | XLEN | Index register contents |
| scale_code | input | 2 | Left-shift amount for the index |
| disp_kind | input | 2 | 00 none, 01 8-bit, 10 32-bit, 11 none |
| disp_raw | input | 32 | Raw displacement bits |
| pc_rel | input | 1 | Relative to the following instruction |
| next_pc | input | XLEN | Address of the following instruction |
| out_valid | output | 1 | Result produced this cycle |
| mem_req | output | 1 | Memory request strobe |
| mem_addr | output | XLEN | Memory request address |
| lea_wr | output | 1 | Address-only result strobe |
| lea_result | output | XLEN | Address-only result value |

## Verification
The bench builds the block with its defaults: XLEN=64, RNUM_W=4 and the stack-pointer number 4. At 64 bits, a negative displacement must fill the whole upper half with ones. A base near the top of the range shows the wrap past 2^64. The 4-bit register number lets the bench sweep the numbers just below and just above the reserved one. It also lets the bench check that only that exact code drops the index.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the address generation unit.
// Assumes: the displacement kind field is two bits wide.
package agu_pkg;
    typedef enum logic [1:0] {
        DISP_NONE = 2'b00,
        DISP_BYTE = 2'b01,
        DISP_WORD = 2'b10,
        DISP_RSVD = 2'b11
    } disp_kind_e;
endpackage

// File: rtl/agu_disp_ext.sv
// Module: agu_disp_ext
// Turns the raw displacement bits into an XLEN-wide signed term.
// Assumes: XLEN > DISP_W > SHORT_W; force_long overrides the kind field.
module agu_disp_ext #(
    parameter int XLEN    = 64,
    parameter int DISP_W  = 32,
    parameter int SHORT_W = 8
) (
    input  logic [1:0]        kind,
    input  logic              force_long,
    input  logic [DISP_W-1:0] raw,
    output logic [XLEN-1:0]   term
);
    import agu_pkg::*;

    logic [XLEN-1:0] long_ext;
    logic [XLEN-1:0] short_ext;
    disp_kind_e      kind_e;

    assign kind_e    = disp_kind_e'(kind);
    assign long_ext  = {{(XLEN-DISP_W){raw[DISP_W-1]}}, raw};
    assign short_ext = {{(XLEN-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};

    // Pick the displacement width requested, or zero.
    always_comb begin
        if (force_long) begin
            term = long_ext;
        end else begin
            case (kind_e)
                DISP_BYTE: term = short_ext;
                DISP_WORD: term = long_ext;
                default:   term = '0;
            endcase
        end
    end
endmodule

// File: rtl/agu_index_scale.sv
// Module: agu_index_scale
// Produces the scaled index term: the index shifted left by the scale code,
// or zero when the index is disabled, suppressed or names the reserved register.
// Assumes: the scale code is a plain shift count (0 .. 2**SCALE_W-1).
module agu_index_scale #(
    parameter int XLEN         = 64,
    parameter int RNUM_W       = 4,
    parameter int NO_INDEX_NUM = 4,
    parameter int SCALE_W      = 2
) (
    input  logic               en,
    input  logic               suppress,
    input  logic [RNUM_W-1:0]  num,
    input  logic [XLEN-1:0]    val,
    input  logic [SCALE_W-1:0] scale,
    output logic [XLEN-1:0]    term
);
    localparam int NSCALE = 1 << SCALE_W;
    localparam logic [RNUM_W-1:0] RESERVED = RNUM_W'(NO_INDEX_NUM);

    logic [XLEN-1:0] shifted [NSCALE];
    logic            use_index;

    // One shifted copy of the index per legal scale code.
    for (genvar g = 0; g < NSCALE; g++) begin : g_shift
        assign shifted[g] = val << g;
    end

    assign use_index = en && !suppress && (num != RESERVED);

    // Select the scaled copy or drop the term.
    always_comb begin
        term = use_index ? shifted[scale] : '0;
    end
endmodule

// File: rtl/agu_sum.sv
// Module: agu_sum
// Three-operand adder for the address terms; carries out of the top bit are dropped.
// Assumes: wraparound modulo 2**XLEN is the wanted behaviour.
module agu_sum #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    output logic [XLEN-1:0] sum
);
    // Combine the three terms in one combinational step.
    always_comb begin
        sum = a + b + c;
    end
endmodule

// File: rtl/agu_core.sv
// Module: agu_core
// Effective address generator: base + (index << scale) + displacement in one
// registered stage, with a memory-request path and a separate address-only path.
// Assumes: register reads and decode happen upstream; synchronous active-low reset.
module agu_core #(
    parameter int XLEN         = 64,
    parameter int RNUM_W       = 4,
    parameter int NO_INDEX_NUM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              lea_op,
    input  logic              base_en,
    input  logic [XLEN-1:0]   base_val,
    input  logic              index_en,
    input  logic [RNUM_W-1:0] index_num,
    input  logic [XLEN-1:0]   index_val,
    input  logic [1:0]        scale_code,
    input  logic [1:0]        disp_kind,
    input  logic [31:0]       disp_raw,
    input  logic              pc_rel,
    input  logic [XLEN-1:0]   next_pc,
    output logic              out_valid,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic              lea_wr,
    output logic [XLEN-1:0]   lea_result
);
    logic [XLEN-1:0] base_term;
    logic [XLEN-1:0] index_term;
    logic [XLEN-1:0] disp_term;
    logic [XLEN-1:0] ea_sum;

    // Base term: next-instruction address in relative mode, else the base or zero.
    always_comb begin
        if (pc_rel)       base_term = next_pc;
        else if (base_en) base_term = base_val;
        else              base_term = '0;
    end

    agu_index_scale #(
        .XLEN(XLEN), .RNUM_W(RNUM_W), .NO_INDEX_NUM(NO_INDEX_NUM), .SCALE_W(2)
    ) u_index (
        .en(index_en), .suppress(pc_rel), .num(index_num),
        .val(index_val), .scale(scale_code), .term(index_term)
    );

    agu_disp_ext #(
        .XLEN(XLEN), .DISP_W(32), .SHORT_W(8)
    ) u_disp (
        .kind(disp_kind), .force_long(pc_rel), .raw(disp_raw), .term(disp_term)
    );

    agu_sum #(.XLEN(XLEN)) u_sum (
        .a(base_term), .b(index_term), .c(disp_term), .sum(ea_sum)
    );

    // Output stage: strobes follow the request, each result port loads only for its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            mem_req    <= 1'b0;
            lea_wr     <= 1'b0;
            mem_addr   <= '0;
            lea_result <= '0;
        end else begin
            out_valid <= in_valid;
            mem_req   <= in_valid && !lea_op;
            lea_wr    <= in_valid && lea_op;
            if (in_valid && !lea_op) mem_addr   <= ea_sum;
            if (in_valid && lea_op)  lea_result <= ea_sum;
        end
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !mem_req && !lea_wr));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && lea_wr));
    assert_lea_keeps_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lea_wr |-> $stable(mem_addr));
    assert_mem_keeps_lea_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $stable(lea_result));
    assert_empty_terms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lea_op && !pc_rel && !base_en && !index_en && disp_kind == 2'b00)
        |=> (mem_addr == '0));
endmodule

// File: tb/tb_agu_core.sv
`timescale 1ns/1ps
module tb_agu_core;
    localparam int XLEN = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, lea_op = 1'b0, base_en = 1'b0, index_en = 1'b0, pc_rel = 1'b0;
    logic [XLEN-1:0]   base_val = '0, index_val = '0, next_pc = '0;
    logic [3:0]        index_num = '0;
    logic [1:0]        scale_code = '0, disp_kind = '0;
    logic [31:0]       disp_raw = '0;
    logic              out_valid, mem_req, lea_wr;
    logic [XLEN-1:0]   mem_addr, lea_result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    agu_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lea_op(lea_op),
        .base_en(base_en), .base_val(base_val), .index_en(index_en),
        .index_num(index_num), .index_val(index_val), .scale_code(scale_code),
        .disp_kind(disp_kind), .disp_raw(disp_raw), .pc_rel(pc_rel), .next_pc(next_pc),
        .out_valid(out_valid), .mem_req(mem_req), .mem_addr(mem_addr),
        .lea_wr(lea_wr), .lea_result(lea_result)
    );

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; results are read one falling edge later.
    task automatic issue(input logic lea, input logic ben, input logic [63:0] b,
                         input logic ien, input logic [3:0] num, input logic [63:0] idx,
                         input logic [1:0] sc, input logic [1:0] dk, input logic [31:0] d,
                         input logic rel, input logic [63:0] npc);
        in_valid = 1'b1; lea_op = lea; base_en = ben; base_val = b;
        index_en = ien; index_num = num; index_val = idx; scale_code = sc;
        disp_kind = dk; disp_raw = d; pc_rel = rel; next_pc = npc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [63:0] sx8(input logic [7:0] v);
        return {{56{v[7]}}, v};
    endfunction
    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic t_reset;
        check("R9 out_valid", 64'(out_valid), 0);
        check("R9 mem_req", 64'(mem_req), 0);
        check("R9 lea_wr", 64'(lea_wr), 0);
        check("R9 mem_addr", mem_addr, 0);
        check("R9 lea_result", lea_result, 0);
    endtask

    task automatic t_full_form;
        issue(0, 1, 64'h1000, 1, 4'd1, 64'd3, 2'd3, 2'b01, 32'h10, 0, 0);
        check("R1 full form", mem_addr, 64'h1028);
        check("R8 valid", 64'(out_valid), 1);
        check("R7 mem_req", 64'(mem_req), 1);
        issue(0, 0, 64'h5555, 1, 4'd2, 64'h40, 2'd1, 2'b00, 32'h7F, 0, 0);
        check("R1 index only", mem_addr, 64'h80);
        issue(0, 1, 64'h2000, 0, 4'd2, 64'hFFFF, 2'd3, 2'b00, 0, 0, 0);
        check("R1 base only", mem_addr, 64'h2000);
    endtask

    task automatic t_scales;
        for (int s = 0; s < 4; s++) begin
            issue(0, 1, 64'h100, 1, 4'd6, 64'h7, 2'(s), 2'b00, 0, 0, 0);
            check($sformatf("R2 scale %0d", s), mem_addr, 64'h100 + (64'h7 << s));
        end
    endtask

    task automatic t_reserved_index;
        issue(0, 1, 64'h300, 1, 4'd4, 64'h55, 2'd2, 2'b00, 0, 0, 0);
        check("R3 reserved index dropped", mem_addr, 64'h300);
        issue(0, 1, 64'h300, 1, 4'd3, 64'h55, 2'd2, 2'b00, 0, 0, 0);
        check("R3 index 3 used", mem_addr, 64'h300 + 64'h154);
        issue(0, 1, 64'h300, 1, 4'd5, 64'h55, 2'd2, 2'b00, 0, 0, 0);
        check("R3 index 5 used", mem_addr, 64'h300 + 64'h154);
    endtask

    task automatic t_disp;
        issue(0, 1, 64'h1000, 0, 0, 0, 0, 2'b01, 32'hABCD_EF80, 0, 0);
        check("R4 byte negative, upper raw ignored", mem_addr, 64'h1000 + sx8(8'h80));
        issue(0, 1, 64'h1000, 0, 0, 0, 0, 2'b10, 32'h8000_0000, 0, 0);
        check("R4 word negative", mem_addr, 64'h1000 + sx32(32'h8000_0000));
        issue(0, 1, 64'h1000, 0, 0, 0, 0, 2'b00, 32'h1234, 0, 0);
        check("R4 kind none", mem_addr, 64'h1000);
        issue(0, 1, 64'h1000, 0, 0, 0, 0, 2'b11, 32'h1234, 0, 0);
        check("R4 kind reserved", mem_addr, 64'h1000);
    endtask

    task automatic t_pcrel;
        issue(0, 1, 64'h9999_0000, 1, 4'd1, 64'h100, 2'd3, 2'b01, 32'hFFFF_FFF0, 1, 64'h40_0000);
        check("R5 relative negative", mem_addr, 64'h3F_FFF0);
        issue(0, 0, 0, 0, 0, 0, 0, 2'b00, 32'h0000_1000, 1, 64'h40_0000);
        check("R5 relative kind none forced", mem_addr, 64'h40_1000);
    endtask

    task automatic t_absolute;
        issue(0, 0, 64'hFFFF, 0, 0, 64'hFFFF, 0, 2'b10, 32'h0060_0000, 0, 64'h1234);
        check("R6 absolute", mem_addr, 64'h60_0000);
        issue(0, 0, 0, 0, 0, 0, 0, 2'b10, 32'h8000_1000, 0, 0);
        check("R6 absolute high", mem_addr, 64'hFFFF_FFFF_8000_1000);
    endtask

    task automatic t_wrap;
        issue(0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 1, 4'd0, 64'h4, 2'd2, 2'b01, 32'h10, 0, 0);
        check("R1 wraparound", mem_addr, 64'h10);
    endtask

    task automatic t_lea;
        logic [63:0] held;
        issue(0, 1, 64'hA000, 0, 0, 0, 0, 2'b00, 0, 0, 0);
        held = mem_addr;
        issue(1, 1, 64'hB000, 1, 4'd2, 64'h3, 2'd2, 2'b01, 32'h8, 0, 0);
        check("R7 lea result", lea_result, 64'hB014);
        check("R7 lea strobe", 64'(lea_wr), 1);
        check("R7 no mem_req on lea", 64'(mem_req), 0);
        check("R7 mem_addr held on lea", mem_addr, held);
        issue(0, 1, 64'hC000, 0, 0, 0, 0, 2'b00, 0, 0, 0);
        check("R7 lea_result held on mem op", lea_result, 64'hB014);
        check("R7 lea_wr low on mem op", 64'(lea_wr), 0);
    endtask

    task automatic t_idle_and_stream;
        logic [63:0] held;
        held = mem_addr;
        base_en = 1'b1; base_val = 64'hDEAD; in_valid = 1'b0;
        @(negedge clk);
        check("R8 idle valid low", 64'(out_valid), 0);
        check("R8 idle mem_req low", 64'(mem_req), 0);
        check("R8 idle addr held", mem_addr, held);
        in_valid = 1'b1; lea_op = 1'b0; pc_rel = 1'b0; index_en = 1'b0;
        disp_kind = 2'b00; base_val = 64'h111;
        @(negedge clk);
        check("R8 stream first", mem_addr, 64'h111);
        base_val = 64'h222;
        @(negedge clk);
        check("R8 stream second", mem_addr, 64'h222);
        check("R8 stream valid", 64'(out_valid), 1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 stream ends", 64'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_form();
        t_scales();
        t_reserved_index();
        t_disp();
        t_pcrel();
        t_absolute();
        t_wrap();
        t_lea();
        t_idle_and_stream();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule